// File: doc/BRIEF.md
# Core Store Queue with Ordering Fences

This block keeps a core's retired stores between the execution pipeline and the level-one data cache. Each store carries a word address, a data word and a byte-enable mask. Entries wait in the queue until the cache write port accepts them. They leave strictly oldest first, at most one per clock.

While stores wait, any load from the same core may take their values. Every slot is compared with the load address in parallel. Bytes from all live matching stores are merged, and a younger store wins over an older one for each byte. The result is a hit only when the merged bytes cover every byte the load asks for.

Two ordering fences are offered. A heavy fence stops new operations from entering until every queued store has reached the cache. A light fence only drops a boundary marker into the queue. Loads made after the marker cannot take data from stores older than it. When the marker reaches the head it is discarded without writing the cache.

Top module: `store_buffer_fence`

## Requirements
- R1: An operation is accepted on a clock where `in_valid` and `in_ready` are both high. `in_ready` is low while the queue holds `DEPTH` entries, and marker entries count toward that total.
- R2: Stores reach the cache port in acceptance order, one per clock where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, `wr_valid` and the presented address and data stay unchanged.
- R3: When several live stores match a load address, the data for each byte comes from the youngest of them.
- R4: Masks of matching stores are merged. `ld_hit` is high only when the merged mask covers every byte set in a nonzero `ld_mask`, and `ld_data` then holds the merged bytes.
- R5: If the merged mask covers some but not all requested bytes, `ld_conflict` is high and `ld_hit` is low. If it covers none, both outputs are low.
- R6: `in_kind` = 2 is a heavy fence. From the clock after it is accepted, `fence_busy` stays high for as long as the queue is not empty, and `in_ready` stays low while `fence_busy` is high.
- R7: `in_kind` = 1 enqueues a boundary marker. While that marker is the youngest marker still queued, stores older than it never contribute to a load result.
- R8: A marker at the head of the queue is removed in one clock whether or not `wr_ready` is high, and it never raises `wr_valid`.
- R9: After a synchronous active-low reset the queue is empty. `in_ready` is high, and `wr_valid`, `fence_busy`, `ld_hit` and `ld_conflict` are low. `in_kind` values 0 and 3 are stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| in_kind | input | 2 | 0/3 store, 1 marker fence, 2 heavy fence |
| in_addr | input | AW | Store word address |
| in_data | input | DW | Store data |
| in_mask | input | DW/8 | Store byte enables |
| fence_busy | output | 1 | Heavy fence waiting for drain |
| ld_addr | input | AW | Load word address |
| ld_mask | input | DW/8 | Requested load bytes |
| ld_hit | output | 1 | Load fully served from queue |
| ld_conflict | output | 1 | Load partly covered by queue |
| ld_data | output | DW | Merged forwarded data |
| wr_valid | output | 1 | Cache write presented |
| wr_ready | input | 1 | Cache accepts write |
| wr_addr | output | AW | Cache write address |
| wr_data | output | DW | Cache write data |
| wr_mask | output | DW/8 | Cache write byte enables |

## Verification
Some rules are checked by assertions on every clock. The occupancy never goes above its bound, and a stalled cache write holds its address and data. A load result is never both a hit and a conflict. A busy heavy fence always holds off the input, and an empty queue neither writes nor forwards.

Other behaviour needs the bench's scenarios. These include youngest-wins byte selection and merging across overlapping stores, and the difference between a miss and a partial conflict. The bench also covers the load boundary set by a marker, the extra clock a marker takes at the head, the drain order seen at the cache port, and the fence clearing exactly when the last store leaves.

// File: rtl/sb_pkg.sv
// Package: shared operation encoding for the store queue.
// Assumes a 2-bit operation field; any code other than MARK or FENCE is a store.
package sb_pkg;
    typedef enum logic [1:0] {
        OP_STORE = 2'd0,
        OP_MARK  = 2'd1,
        OP_FENCE = 2'd2,
        OP_STALT = 2'd3
    } sb_op_e;
endpackage

// File: rtl/sb_addr_match.sv
// Module: per-slot parallel address comparator.
// Compares every slot's word address with the load address.
// Assumes eligibility (live, store and not behind a marker) is worked out by the caller.
module sb_addr_match #(
    parameter int DEPTH = 36,
    parameter int AW    = 32
) (
    input  logic [DEPTH-1:0][AW-1:0] slot_addr,
    input  logic [DEPTH-1:0]         slot_elig,
    input  logic [AW-1:0]            ld_addr,
    output logic [DEPTH-1:0]         hit_vec
);
    // One comparator for each slot.
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign hit_vec[i] = slot_elig[i] && (slot_addr[i] == ld_addr);
    end
endmodule

// File: rtl/sb_fwd_merge.sv
// Module: byte merge of matching slots, walked from oldest to youngest.
// A younger slot overwrites an older one byte by byte, so the youngest writer wins.
// Assumes head < DEPTH.
module sb_fwd_merge #(
    parameter int DEPTH = 36,
    parameter int DW    = 64,
    localparam int MW   = DW / 8,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]         hit_vec,
    input  logic [DEPTH-1:0][DW-1:0] slot_data,
    input  logic [DEPTH-1:0][MW-1:0] slot_mask,
    input  logic [PW-1:0]            head,
    output logic [DW-1:0]            merged,
    output logic [MW-1:0]            covered
);
    // Walk the slots in age order and let later writers overwrite bytes.
    always_comb begin
        merged  = '0;
        covered = '0;
        for (int k = 0; k < DEPTH; k++) begin
            logic [PW:0] s;
            s = {1'b0, head} + (PW+1)'(k);
            if (s >= (PW+1)'(DEPTH)) s = s - (PW+1)'(DEPTH);
            if (hit_vec[s[PW-1:0]]) begin
                for (int b = 0; b < MW; b++) begin
                    if (slot_mask[s[PW-1:0]][b])
                        merged[b*8 +: 8] = slot_data[s[PW-1:0]][b*8 +: 8];
                end
                covered = covered | slot_mask[s[PW-1:0]];
            end
        end
    end
endmodule

// File: rtl/store_buffer_fence.sv
// Module: store queue with load forwarding and two fence styles.
// Holds stores in a circular FIFO, drains them in order to a ready/valid cache
// port, forwards merged bytes to loads, and supports heavy and marker fences.
// Assumes DEPTH >= 2; loads are looked up combinationally against registered state.
module store_buffer_fence
    import sb_pkg::*;
#(
    parameter int DEPTH = 36,
    parameter int AW    = 32,
    parameter int DW    = 64,
    localparam int MW   = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [1:0]    in_kind,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    input  logic [MW-1:0] in_mask,
    output logic          fence_busy,
    input  logic [AW-1:0] ld_addr,
    input  logic [MW-1:0] ld_mask,
    output logic          ld_hit,
    output logic          ld_conflict,
    output logic [DW-1:0] ld_data,
    output logic          wr_valid,
    input  logic          wr_ready,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic [MW-1:0] wr_mask
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [DEPTH-1:0][AW-1:0] e_addr;
    logic [DEPTH-1:0][DW-1:0] e_data;
    logic [DEPTH-1:0][MW-1:0] e_mask;
    logic [DEPTH-1:0]         e_mark;
    logic [PW-1:0]            head, tail, mark_slot;
    logic [CW-1:0]            count;
    logic                     mark_live, fence_pend;
    logic                     is_fence, is_mark, accept, enq, pop, head_mark;
    logic [DEPTH-1:0]         elig, hit_vec;
    logic [MW-1:0]            covered;
    logic [CW-1:0]            mark_age;

    // Age of a slot relative to the head (0 = oldest).
    function automatic logic [CW-1:0] age_of(input logic [PW-1:0] slot, input logic [PW-1:0] hd);
        logic [CW-1:0] a;
        a = {1'b0, slot} - {1'b0, hd};
        if (slot < hd) a = a + FULL_CNT;
        return a;
    endfunction

    // Advance a slot pointer with wrap at DEPTH.
    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Input decode and handshake.
    always_comb begin
        is_fence   = (in_kind == OP_FENCE);
        is_mark    = (in_kind == OP_MARK);
        fence_busy = fence_pend && (count != '0);
        in_ready   = (count != FULL_CNT) && !fence_busy;
        accept     = in_valid && in_ready;
        enq        = accept && !is_fence;
    end

    // Head drain: markers retire silently, stores wait for the cache.
    always_comb begin
        head_mark = e_mark[head];
        wr_valid  = (count != '0) && !head_mark;
        wr_addr   = e_addr[head];
        wr_data   = e_data[head];
        wr_mask   = e_mask[head];
        pop       = (count != '0) && (head_mark || wr_ready);
    end

    // Slot payload writes on enqueue.
    always_ff @(posedge clk) begin
        if (enq) begin
            e_addr[tail] <= in_addr;
            e_data[tail] <= in_data;
            e_mask[tail] <= is_mark ? '0 : in_mask;
            e_mark[tail] <= is_mark;
        end
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (enq) tail <= step(tail);
            if (pop) head <= step(head);
            count <= count + CW'(enq) - CW'(pop);
        end
    end

    // Youngest queued marker tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mark_live <= 1'b0;
            mark_slot <= '0;
        end else if (enq && is_mark) begin
            mark_live <= 1'b1;
            mark_slot <= tail;
        end else if (pop && head_mark && (head == mark_slot)) begin
            mark_live <= 1'b0;
        end
    end

    // Heavy fence pending flag, dropped once the queue is seen empty.
    always_ff @(posedge clk) begin
        if (!rst_n)                  fence_pend <= 1'b0;
        else if (accept && is_fence) fence_pend <= 1'b1;
        else if (count == '0)        fence_pend <= 1'b0;
    end

    // Slot eligibility for forwarding: live, a store, and younger than the marker.
    assign mark_age = age_of(mark_slot, head);
    for (genvar i = 0; i < DEPTH; i++) begin : g_elig
        logic [CW-1:0] a;
        assign a       = age_of(PW'(i), head);
        assign elig[i] = (a < count) && !e_mark[i] && (!mark_live || (a > mark_age));
    end

    sb_addr_match #(.DEPTH(DEPTH), .AW(AW)) u_match (
        .slot_addr (e_addr),
        .slot_elig (elig),
        .ld_addr   (ld_addr),
        .hit_vec   (hit_vec)
    );

    sb_fwd_merge #(.DEPTH(DEPTH), .DW(DW)) u_merge (
        .hit_vec   (hit_vec),
        .slot_data (e_data),
        .slot_mask (e_mask),
        .head      (head),
        .merged    (ld_data),
        .covered   (covered)
    );

    // Load verdict from merged coverage.
    always_comb begin
        ld_hit      = (ld_mask != '0) && ((covered & ld_mask) == ld_mask);
        ld_conflict = ((covered & ld_mask) != '0) && !ld_hit;
    end

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);
    assert_wr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
    assert_ld_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_hit && ld_conflict));
    assert_fence_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fence_busy |-> !in_ready);
    assert_empty_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> (!wr_valid && !ld_hit && !ld_conflict));
endmodule

// File: tb/sim_store_buffer_fence.sv
module sim_store_buffer_fence;
    localparam int CLK_P = 10;
    localparam int DEPTH = 36;
    localparam int AW = 32;
    localparam int DW = 64;
    localparam int MW = 8;
    localparam int NV = 7;
    // {addr, mask, hit, conflict, data}
    localparam logic [105:0] VEC [NV] = '{
        {32'd10, 8'hFF, 1'b1, 1'b0, 64'h1111_1111_2222_2222},
        {32'd20, 8'hFF, 1'b1, 1'b0, 64'hBBBB_BBBB_AAAA_AAAA},
        {32'd20, 8'h0F, 1'b1, 1'b0, 64'h0000_0000_AAAA_AAAA},
        {32'd30, 8'hFF, 1'b0, 1'b0, 64'h0},
        {32'd40, 8'hFF, 1'b0, 1'b1, 64'h0},
        {32'd40, 8'h01, 1'b1, 1'b0, 64'h0000_0000_0000_0044},
        {32'd40, 8'h0C, 1'b0, 1'b0, 64'h0}
    };

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, in_ready;
    logic [1:0] in_kind = 0;
    logic [AW-1:0] in_addr = 0;
    logic [DW-1:0] in_data = 0;
    logic [MW-1:0] in_mask = 0;
    logic fence_busy;
    logic [AW-1:0] ld_addr = 0;
    logic [MW-1:0] ld_mask = 0;
    logic ld_hit, ld_conflict;
    logic [DW-1:0] ld_data;
    logic wr_valid, wr_ready = 0;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic [MW-1:0] wr_mask;
    int checks = 0, fails = 0;

    always #(CLK_P/2) clk = ~clk;

    store_buffer_fence #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u0 (.*);

    function automatic logic [DW-1:0] bytes_of(input logic [MW-1:0] m);
        logic [DW-1:0] r = '0;
        for (int b = 0; b < MW; b++) if (m[b]) r[b*8 +: 8] = 8'hFF;
        return r;
    endfunction

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R3";
            1, 2, 5: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [1:0] k, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [MW-1:0] m);
        while (!in_ready) begin @(posedge clk); #1; end
        in_valid = 1; in_kind = k; in_addr = a; in_data = d; in_mask = m;
        @(posedge clk); #1;
        in_valid = 0;
    endtask

    task automatic look(input logic [AW-1:0] a, input logic [MW-1:0] m, input bit eh, input bit ec,
                        input logic [DW-1:0] ed, input string tag);
        ld_addr = a; ld_mask = m; #1;
        chk(ld_hit == eh && ld_conflict == ec, tag, {62'd0, ld_hit, ld_conflict}, {62'd0, eh, ec});
        if (eh) chk((ld_data & bytes_of(m)) == (ed & bytes_of(m)), tag, ld_data, ed);
    endtask

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [AW-1:0] exp_a [6] = '{32'd10, 32'd20, 32'd10, 32'd20, 32'd40, 32'd10};
        logic [DW-1:0] exp_d [6] = '{64'h1111_1111_1111_1111, 64'hAAAA_AAAA_AAAA_AAAA,
                                     64'h2222_2222_2222_2222, 64'hBBBB_BBBB_BBBB_BBBB,
                                     64'h4444_4444_4444_4444, 64'h3333_3333_3333_3333};
        int got;
        int last_cyc;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R9 reset state
        ld_addr = 10; ld_mask = 8'hFF; #1;
        chk(in_ready && !wr_valid && !fence_busy && !ld_hit && !ld_conflict, "R9",
            {59'd0, in_ready, wr_valid, fence_busy, ld_hit, ld_conflict}, 64'h10);

        // Preload the queue with overlapping stores, cache stalled
        push(2'd0, 10, 64'h1111_1111_1111_1111, 8'hFF);
        push(2'd0, 20, 64'hAAAA_AAAA_AAAA_AAAA, 8'h0F);
        push(2'd0, 10, 64'h2222_2222_2222_2222, 8'h0F);
        push(2'd3, 20, 64'hBBBB_BBBB_BBBB_BBBB, 8'hF0);
        push(2'd0, 40, 64'h4444_4444_4444_4444, 8'h03);
        for (int i = 0; i < NV; i++)
            look(VEC[i][105:74], VEC[i][73:66], VEC[i][65], VEC[i][64], VEC[i][63:0], vec_tag(i));

        // R2 stall: head held while cache not ready
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(wr_valid && wr_addr == 10 && wr_data == 64'h1111_1111_1111_1111, "R2", wr_data, 64'h1111_1111_1111_1111);
        end

        // R7 marker boundary
        @(posedge clk); #1;
        push(2'd1, 0, 0, 0);
        push(2'd0, 10, 64'h3333_3333_3333_3333, 8'hFF);
        look(10, 8'hFF, 1, 0, 64'h3333_3333_3333_3333, "R7");
        look(20, 8'h0F, 0, 0, 0, "R7");
        look(40, 8'h01, 0, 0, 0, "R7");

        // R2/R8 drain order and silent marker
        wr_ready = 1; got = 0; last_cyc = -1;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (wr_valid) begin
                if (got < 6) begin
                    chk(wr_addr == exp_a[got] && wr_data == exp_d[got], "R2", wr_data, exp_d[got]);
                end
                got++; last_cyc = c;
            end
        end
        chk(got == 6, "R8", 64'(got), 64'd6);
        chk(last_cyc == 6, "R8", 64'(last_cyc), 64'd6);
        wr_ready = 0;

        // R1 full queue
        for (int i = 0; i < DEPTH; i++) push(2'd0, 32'(100 + i), 64'(i), 8'hFF);
        #1;
        chk(!in_ready, "R1", {63'd0, in_ready}, 64'd0);
        look(32'(100 + DEPTH - 1), 8'hFF, 1, 0, 64'(DEPTH - 1), "R1");
        look(100, 8'hFF, 1, 0, 64'd0, "R1");
        wr_ready = 1;
        repeat (DEPTH) @(posedge clk);
        @(negedge clk);
        chk(!wr_valid && in_ready, "R1", {62'd0, wr_valid, in_ready}, 64'd1);
        wr_ready = 0;

        // R6 heavy fence
        @(posedge clk); #1;
        push(2'd0, 200, 64'h55, 8'hFF);
        push(2'd0, 201, 64'h66, 8'hFF);
        push(2'd2, 0, 0, 0);
        chk(fence_busy && !in_ready, "R6", {62'd0, fence_busy, in_ready}, 64'd2);
        wr_ready = 1;
        @(posedge clk); #1;
        chk(fence_busy && !in_ready, "R6", {62'd0, fence_busy, in_ready}, 64'd2);
        @(posedge clk); #1;
        chk(!fence_busy && in_ready, "R6", {62'd0, fence_busy, in_ready}, 64'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule